// File: doc/BRIEF.md
# Bus Prefetch and Posted-Write Buffer

This block sits between a host-side slave port and a slow external memory sequencer that serves four equal memory banks, selected by the top address bits. It cuts host stall time in two ways. A write that cannot fail is taken into a single 32-bit posted-write register and acknowledged at once, while the block drains it to the sequencer. After a read completes, the block speculatively fetches the next sequential item of the same width and keeps it in a one-entry prefetch store. A later matching read is then served from that store without any external access.

Each bank has a prefetch-enable bit and a write-buffer-disable bit. A select input chooses between two schemes: bank 0's bits govern every bank, or each bank uses its own bits. The `busy` output stays high while any external transaction that the block started is still outstanding. This includes a draining posted write and a speculative prefetch. All accesses reach the sequencer in host order. A host request that arrives while the block is busy waits until it is idle again.

Top module: `bus_pfwb`

## Requirements
- R1: After reset, `busy`, `x_req` and `h_done` are all low.
- R2: A read that misses the prefetch store issues one external read with the same address and size, and completes with the data returned by the sequencer.
- R3: When a read completes and prefetch is enabled for its bank, the block issues an external read at the address plus the read's byte count (size code 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes), with the same size code. `busy` stays high until that read is done.
- R4: When prefetch is disabled for the bank, a completed read causes no further external access.
- R5: A prefetch whose next address falls in a different bank (bank = address bits [15:14]) or past the top of the address space is not issued.
- R6: A read whose address and size code both equal those of the valid prefetched item completes in the cycle it is presented, returns the prefetched data, and makes no external read of that address.
- R7: A write never causes a prefetch.
- R8: A write to a bank whose buffer is enabled, with `h_nofail` high, completes in the cycle it is presented. It is then written externally, and `busy` stays high until that write is done.
- R9: A write with `h_nofail` low, or to a bank whose buffer is disabled, completes only in the cycle in which the sequencer reports `x_done`.
- R10: With `cfg_indiv` = 0, bit 0 of `cfg_pf_en` and bit 0 of `cfg_wb_dis` apply to all banks. With `cfg_indiv` = 1, bank b uses bit b of each.
- R11: A request presented while a posted write is draining waits. External accesses occur in host order, and the posted write goes first.
- R12: A write whose word address (bits [15:2]) equals that of the prefetched item invalidates it, so a later read of that item goes external.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_indiv | input | 1 | 0: bank 0 settings for all banks; 1: per-bank settings |
| cfg_pf_en | input | 4 | Per-bank prefetch enable |
| cfg_wb_dis | input | 4 | Per-bank write-buffer disable |
| h_req | input | 1 | Host request, held until `h_done` |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 16 | Host byte address |
| h_size | input | 2 | Access size code: 0 byte, 1 half, 2 word |
| h_wdata | input | 32 | Host write data |
| h_nofail | input | 1 | This write cannot fault externally |
| h_done | output | 1 | Host request completes this cycle |
| h_rdata | output | 32 | Read data, valid with `h_done` |
| x_req | output | 1 | External request, held until `x_done` |
| x_we | output | 1 | External write (1) or read (0) |
| x_addr | output | 16 | External address |
| x_size | output | 2 | External size code |
| x_wdata | output | 32 | External write data |
| x_done | input | 1 | Sequencer finished the current request |
| x_rdata | input | 32 | Sequencer read data, valid with `x_done` |
| busy | output | 1 | External activity outstanding |

## Verification
The bench drives each host request just after a falling edge and samples the outputs 1 ns later. A prefetch hit or a posted write must show `h_done` at that very first sample, with no clock edge between. A miss or an unposted write must show `h_done` only together with `x_done`, three cycles after `x_req` rises with the modelled sequencer. One cycle after a read or a posted write is acknowledged, `busy` is sampled and must be high. Every external access is checked against a queue of expected accesses, in order, at the cycle of its `x_done`. Once `busy` drops, the queue must be empty, which catches both missing accesses and extra prefetches.

// File: rtl/pfwb_pkg.sv
package pfwb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD    = 3'd1,
    ST_WR    = 3'd2,
    ST_DRAIN = 3'd3,
    ST_PF    = 3'd4
  } pfwb_state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/pfwb_bank_cfg.sv
module pfwb_bank_cfg #(
  parameter int NBANK = 4
) (
  input  logic             cfg_indiv,
  input  logic [NBANK-1:0] cfg_pf_en,
  input  logic [NBANK-1:0] cfg_wb_dis,
  output logic [NBANK-1:0] pf_en_eff,
  output logic [NBANK-1:0] wb_en_eff
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    // R10: common or per-bank selection
    assign pf_en_eff[b] = cfg_indiv ? cfg_pf_en[b]   : cfg_pf_en[0];
    assign wb_en_eff[b] = cfg_indiv ? !cfg_wb_dis[b] : !cfg_wb_dis[0];
  end
endmodule

// File: rtl/pfwb_pf_store.sv
module pfwb_pf_store #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [1:0]    load_size,
  input  logic [DW-1:0] load_data,
  input  logic          inval,
  input  logic [AW-1:0] inval_addr,
  input  logic [AW-1:0] look_addr,
  input  logic [1:0]    look_size,
  output logic          hit,
  output logic [DW-1:0] hit_data
);
  logic          vld_q, vld_d;
  logic [AW-1:0] addr_q;
  logic [1:0]    size_q;
  logic [DW-1:0] data_q;

  always_comb begin
    vld_d = vld_q;
    if (load) begin
      vld_d = 1'b1;
    end else if (inval && (inval_addr[AW-1:2] == addr_q[AW-1:2])) begin
      vld_d = 1'b0;  // R12
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      size_q <= '0;
      data_q <= '0;
    end else if (load) begin
      addr_q <= load_addr;
      size_q <= load_size;
      data_q <= load_data;
    end
  end

  assign hit      = vld_q && (look_addr == addr_q) && (look_size == size_q);
  assign hit_data = data_q;

  AST_INVAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (inval && !load && vld_q && inval_addr[AW-1:2] == addr_q[AW-1:2])
      |=> !hit) else $error("invalidated entry still hits");  // R12
endmodule

// File: rtl/pfwb_ctrl.sv
module pfwb_ctrl
  import pfwb_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int NBANK = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBANK-1:0] pf_en_eff,
  input  logic [NBANK-1:0] wb_en_eff,
  input  logic             h_req,
  input  logic             h_we,
  input  logic [AW-1:0]    h_addr,
  input  logic [1:0]       h_size,
  input  logic [DW-1:0]    h_wdata,
  input  logic             h_nofail,
  output logic             h_done,
  output logic [DW-1:0]    h_rdata,
  output logic             x_req,
  output logic             x_we,
  output logic [AW-1:0]    x_addr,
  output logic [1:0]       x_size,
  output logic [DW-1:0]    x_wdata,
  input  logic             x_done,
  input  logic [DW-1:0]    x_rdata,
  input  logic             pf_hit,
  input  logic [DW-1:0]    pf_hit_data,
  output logic             pf_load,
  output logic             pf_inval,
  output logic             busy
);
  localparam int BW = $clog2(NBANK);

  pfwb_state_e   st_q, st_d;
  logic [AW-1:0] op_addr_q, op_addr_d;
  logic [1:0]    op_size_q, op_size_d;
  logic [DW-1:0] op_wdata_q, op_wdata_d;
  logic          op_we_q, op_we_d;
  logic          op_ld;

  logic          take, rd_hit, wr_buf;
  logic [AW-1:0] base_addr;
  logic [1:0]    base_size;
  logic [AW:0]   step, nxt;
  logic          pf_ok;

  assign take   = (st_q == ST_IDLE) && h_req;
  assign rd_hit = take && !h_we && pf_hit;
  assign wr_buf = take && h_we && h_nofail && wb_en_eff[h_addr[AW-1 -: BW]];

  // next sequential item of the same width, same bank only (R3, R5)
  assign base_addr = (st_q == ST_IDLE) ? h_addr : op_addr_q;
  assign base_size = (st_q == ST_IDLE) ? h_size : op_size_q;
  assign step      = (AW+1)'(1) << base_size;
  assign nxt       = {1'b0, base_addr} + step;
  assign pf_ok     = pf_en_eff[base_addr[AW-1 -: BW]] && !nxt[AW] &&
                     (nxt[AW-1 -: BW] == base_addr[AW-1 -: BW]);

  always_comb begin
    st_d       = st_q;
    op_ld      = 1'b0;
    op_addr_d  = op_addr_q;
    op_size_d  = op_size_q;
    op_wdata_d = op_wdata_q;
    op_we_d    = op_we_q;
    case (st_q)
      ST_IDLE: begin
        if (take) begin
          if (rd_hit) begin
            if (pf_ok) begin
              st_d      = ST_PF;
              op_ld     = 1'b1;
              op_addr_d = nxt[AW-1:0];
              op_size_d = h_size;
              op_we_d   = 1'b0;
            end
          end else begin
            op_ld      = 1'b1;
            op_addr_d  = h_addr;
            op_size_d  = h_size;
            op_wdata_d = h_wdata;
            op_we_d    = h_we;
            if (!h_we)       st_d = ST_RD;
            else if (wr_buf) st_d = ST_DRAIN;
            else             st_d = ST_WR;
          end
        end
      end
      ST_RD: begin
        if (x_done) begin
          if (pf_ok) begin
            st_d      = ST_PF;
            op_ld     = 1'b1;
            op_addr_d = nxt[AW-1:0];
            op_we_d   = 1'b0;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_WR, ST_DRAIN, ST_PF: begin
        if (x_done) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_addr_q  <= '0;
      op_size_q  <= '0;
      op_wdata_q <= '0;
      op_we_q    <= 1'b0;
    end else if (op_ld) begin
      op_addr_q  <= op_addr_d;
      op_size_q  <= op_size_d;
      op_wdata_q <= op_wdata_d;
      op_we_q    <= op_we_d;
    end
  end

  assign h_done   = rd_hit || wr_buf ||
                    (((st_q == ST_RD) || (st_q == ST_WR)) && x_done);
  assign h_rdata  = (st_q == ST_RD) ? x_rdata : pf_hit_data;
  assign x_req    = (st_q != ST_IDLE);
  assign x_we     = op_we_q;
  assign x_addr   = op_addr_q;
  assign x_size   = op_size_q;
  assign x_wdata  = op_wdata_q;
  assign pf_load  = (st_q == ST_PF) && x_done;
  assign pf_inval = take && h_we;
  assign busy     = (st_q != ST_IDLE);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !x_req) else $error("request during reset");  // R1
  AST_EXT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (x_req && !x_done) |=> (x_req && $stable(x_addr) && $stable(x_we)))
    else $error("external request dropped early");  // R2
  AST_BUSY_COVERS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    x_req |-> busy) else $error("busy low with access open");  // R8
  AST_WRITE_NO_PF: assert property (@(posedge clk) disable iff (!rst_n)
    (x_req && x_we && x_done) |=> !x_req) else $error("access after write");  // R7
  AST_BUF_NEEDS_NOFAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (h_done && h_we && !x_req) |-> h_nofail) else $error("faultable write posted");  // R9
  AST_DRAIN_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DRAIN) |-> !h_done) else $error("request passed drain");  // R11
endmodule

// File: rtl/bus_pfwb.sv
module bus_pfwb #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int NBANK = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_indiv,
  input  logic [NBANK-1:0] cfg_pf_en,
  input  logic [NBANK-1:0] cfg_wb_dis,
  input  logic             h_req,
  input  logic             h_we,
  input  logic [AW-1:0]    h_addr,
  input  logic [1:0]       h_size,
  input  logic [DW-1:0]    h_wdata,
  input  logic             h_nofail,
  output logic             h_done,
  output logic [DW-1:0]    h_rdata,
  output logic             x_req,
  output logic             x_we,
  output logic [AW-1:0]    x_addr,
  output logic [1:0]       x_size,
  output logic [DW-1:0]    x_wdata,
  input  logic             x_done,
  input  logic [DW-1:0]    x_rdata,
  output logic             busy
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [NBANK-1:0] pf_en_eff, wb_en_eff;
  logic             pf_hit, pf_load, pf_inval;
  logic [DW-1:0]    pf_hit_data;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  pfwb_bank_cfg #(.NBANK(NBANK)) i_cfg (
    .cfg_indiv (cfg_indiv),
    .cfg_pf_en (cfg_pf_en),
    .cfg_wb_dis(cfg_wb_dis),
    .pf_en_eff (pf_en_eff),
    .wb_en_eff (wb_en_eff)
  );

  pfwb_pf_store #(.AW(AW), .DW(DW)) i_store (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load      (pf_load),
    .load_addr (x_addr),
    .load_size (x_size),
    .load_data (x_rdata),
    .inval     (pf_inval),
    .inval_addr(h_addr),
    .look_addr (h_addr),
    .look_size (h_size),
    .hit       (pf_hit),
    .hit_data  (pf_hit_data)
  );

  pfwb_ctrl #(.AW(AW), .DW(DW), .NBANK(NBANK)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .pf_en_eff  (pf_en_eff),
    .wb_en_eff  (wb_en_eff),
    .h_req      (h_req),
    .h_we       (h_we),
    .h_addr     (h_addr),
    .h_size     (h_size),
    .h_wdata    (h_wdata),
    .h_nofail   (h_nofail),
    .h_done     (h_done),
    .h_rdata    (h_rdata),
    .x_req      (x_req),
    .x_we       (x_we),
    .x_addr     (x_addr),
    .x_size     (x_size),
    .x_wdata    (x_wdata),
    .x_done     (x_done),
    .x_rdata    (x_rdata),
    .pf_hit     (pf_hit),
    .pf_hit_data(pf_hit_data),
    .pf_load    (pf_load),
    .pf_inval   (pf_inval),
    .busy       (busy)
  );
endmodule

// File: tb/test_bus_pfwb.sv
module test_bus_pfwb;
  localparam int LAT = 3;

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [1:0]  sz;
  } ext_t;

  logic        clk, rst_n;
  logic        cfg_indiv;
  logic [3:0]  cfg_pf_en, cfg_wb_dis;
  logic        h_req, h_we, h_nofail, h_done;
  logic [15:0] h_addr, x_addr;
  logic [1:0]  h_size, x_size;
  logic [31:0] h_wdata, h_rdata, x_wdata, x_rdata;
  logic        x_req, x_we, x_done, busy;
  logic [2:0]  lat_cnt;

  int   checks = 0;
  int   fails  = 0;
  ext_t exp_q[$];

  bus_pfwb i_bus_pfwb (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] mem_val(input logic [15:0] a);
    return {16'h5A5A ^ a, a};
  endfunction

  // modelled external sequencer: fixed latency
  assign x_rdata = mem_val(x_addr);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cnt <= '0;
      x_done  <= 1'b0;
    end else begin
      x_done <= 1'b0;
      if (x_req && !x_done) begin
        if (lat_cnt == 3'(LAT - 1)) begin
          x_done  <= 1'b1;
          lat_cnt <= '0;
        end else begin
          lat_cnt <= lat_cnt + 3'd1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_ext(input logic we, input logic [15:0] a, input logic [1:0] sz);
    exp_q.push_back('{we: we, addr: a, sz: sz});
  endtask

  // monitor: compare each finished external access against the queue
  always @(negedge clk) begin
    if (rst_n && x_req && x_done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4/R5/R7", "unexpected access", {13'd0, x_we, x_addr, x_size}, 32'd0);
      end else begin
        ext_t e;
        e = exp_q.pop_front();
        check({x_we, x_addr, x_size} == e, "R2/R3/R11", "access order",
              {13'd0, x_we, x_addr, x_size}, {13'd0, e});
      end
    end
  end

  task automatic host(input logic we, input logic [15:0] a, input logic [1:0] sz,
                      input logic nf, output int n, output logic [31:0] rd,
                      output logic xd_seen);
    @(negedge clk);
    h_req = 1'b1; h_we = we; h_addr = a; h_size = sz;
    h_wdata = ~mem_val(a); h_nofail = nf;
    n = 0;
    forever begin
      #1;
      if (h_done || n > 200) break;
      @(negedge clk);
      n++;
    end
    rd = h_rdata;
    xd_seen = x_done;
    @(posedge clk);
    #1 h_req = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int k = 0;
    @(negedge clk);
    while (busy && k < 100) begin
      @(negedge clk);
      k++;
    end
    check(exp_q.size() == 0, req, "pending expected accesses", exp_q.size(), 0);
  endtask

  task automatic do_read(input logic [15:0] a, input logic [1:0] sz,
                         input bit want_hit, input string req);
    int n; logic [31:0] rd; logic xd;
    host(1'b0, a, sz, 1'b0, n, rd, xd);
    check(rd == mem_val(a), req, "read data", rd, mem_val(a));
    check(want_hit ? (n == 0) : (n > 0 && xd), req, "read completion cycle",
          n, want_hit ? 0 : LAT);
  endtask

  task automatic do_write(input logic [15:0] a, input logic nf,
                          input bit want_post, input string req);
    int n; logic [31:0] rd; logic xd;
    expect_ext(1'b1, a, 2'd2);
    host(1'b1, a, 2'd2, nf, n, rd, xd);
    if (want_post) begin
      check(n == 0, req, "posted write completes at once", n, 0);
      #0 check(busy == 1'b1, req, "busy after posted write", busy, 1);
    end else begin
      check(n > 0 && xd, req, "unposted write waits for x_done", n, LAT);
    end
  endtask

  initial begin
    int n; logic [31:0] rd; logic xd;
    rst_n = 1'b0; h_req = 1'b0; h_we = 1'b0; h_addr = '0; h_size = '0;
    h_wdata = '0; h_nofail = 1'b0;
    cfg_indiv = 1'b1; cfg_pf_en = 4'b1111; cfg_wb_dis = 4'b0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !x_req && !h_done, "R1", "reset outputs",
          {busy, x_req, h_done}, 0);

    // R2 miss, R3 prefetch of next word
    expect_ext(1'b0, 16'h0100, 2'd2); expect_ext(1'b0, 16'h0104, 2'd2);
    do_read(16'h0100, 2'd2, 1'b0, "R2");
    check(busy == 1'b1, "R3", "busy during prefetch", busy, 1);
    wait_idle("R3");

    // R6 hit, then chained prefetch
    expect_ext(1'b0, 16'h0108, 2'd2);
    do_read(16'h0104, 2'd2, 1'b1, "R6");
    wait_idle("R6");

    // size mismatch misses; R3 halfword width
    expect_ext(1'b0, 16'h0108, 2'd1); expect_ext(1'b0, 16'h010A, 2'd1);
    do_read(16'h0108, 2'd1, 1'b0, "R6");
    wait_idle("R3");

    // R5 bank boundary
    expect_ext(1'b0, 16'h3FFC, 2'd2);
    do_read(16'h3FFC, 2'd2, 1'b0, "R5");
    wait_idle("R5");
    expect_ext(1'b0, 16'hFFFE, 2'd1);
    do_read(16'hFFFE, 2'd1, 1'b0, "R5");
    wait_idle("R5");
    expect_ext(1'b0, 16'h3FFE, 2'd0); expect_ext(1'b0, 16'h3FFF, 2'd0);
    do_read(16'h3FFE, 2'd0, 1'b0, "R3");
    wait_idle("R3");

    // R4 prefetch disabled for bank 1
    cfg_pf_en = 4'b1101;
    expect_ext(1'b0, 16'h4010, 2'd2);
    do_read(16'h4010, 2'd2, 1'b0, "R4");
    wait_idle("R4");

    // R10 common vs individual selection
    cfg_indiv = 1'b0; cfg_pf_en = 4'b0001;
    expect_ext(1'b0, 16'h8020, 2'd2); expect_ext(1'b0, 16'h8024, 2'd2);
    do_read(16'h8020, 2'd2, 1'b0, "R10");
    wait_idle("R10");
    cfg_pf_en = 4'b1110;
    expect_ext(1'b0, 16'h8040, 2'd2);
    do_read(16'h8040, 2'd2, 1'b0, "R10");
    wait_idle("R10");
    cfg_indiv = 1'b1;
    expect_ext(1'b0, 16'h8060, 2'd2); expect_ext(1'b0, 16'h8064, 2'd2);
    do_read(16'h8060, 2'd2, 1'b0, "R10");
    wait_idle("R10");
    cfg_pf_en = 4'b1111;

    // R8 posted write, R7 no prefetch after it
    do_write(16'h0200, 1'b1, 1'b1, "R8");
    wait_idle("R7");
    // R9 faultable write is not posted
    do_write(16'h0204, 1'b0, 1'b0, "R9");
    wait_idle("R9");
    // R10 buffer disable, common then individual
    cfg_indiv = 1'b0; cfg_wb_dis = 4'b0001;
    do_write(16'h4100, 1'b1, 1'b0, "R10");
    wait_idle("R10");
    cfg_indiv = 1'b1;
    do_write(16'h4104, 1'b1, 1'b1, "R10");
    wait_idle("R10");
    do_write(16'h0208, 1'b1, 1'b0, "R9");
    wait_idle("R9");
    cfg_wb_dis = 4'b0000;

    // R11 read behind a draining write
    do_write(16'h0300, 1'b1, 1'b1, "R11");
    expect_ext(1'b0, 16'h0400, 2'd2); expect_ext(1'b0, 16'h0404, 2'd2);
    host(1'b0, 16'h0400, 2'd2, 1'b0, n, rd, xd);
    check(n >= 2 * LAT, "R11", "read waited for drain", n, 2 * LAT);
    check(rd == mem_val(16'h0400), "R11", "read data", rd, mem_val(16'h0400));
    wait_idle("R11");

    // R12 write invalidates prefetched item
    expect_ext(1'b0, 16'h0500, 2'd2); expect_ext(1'b0, 16'h0504, 2'd2);
    do_read(16'h0500, 2'd2, 1'b0, "R12");
    wait_idle("R12");
    do_write(16'h0506, 1'b1, 1'b1, "R12");
    wait_idle("R12");
    expect_ext(1'b0, 16'h0504, 2'd2); expect_ext(1'b0, 16'h0508, 2'd2);
    do_read(16'h0504, 2'd2, 1'b0, "R12");
    wait_idle("R12");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule